// File: doc/BRIEF.md
# Programmable Sample Delay Line over External Dual-Port RAM

This block delays a stream of data words by a number of accepted samples that can be changed while the block runs. It keeps no storage of its own. For every accepted word it drives the write side of an external dual-port block RAM and addresses the read side at the slot written that many samples earlier. The word that the RAM returns is then presented downstream with a valid strobe. Everything is on one clock. The RAM must be clocked by the same clock and must register its read data with exactly one cycle of latency.

The delay line only moves when words arrive. Each accepted input word produces at most one output word, two cycles later. A gap in the input stream therefore gives a matching gap at the output. A delay value of zero bypasses the RAM through a register pipeline of the same length, so the timing does not change. After reset, and after any change of the effective delay, the output stays silent until the RAM holds enough fresh words. Stale contents therefore never appear at the output. A delay value the RAM cannot hold is limited to the largest one it can.

Top module: `vardly_buf`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and the first accepted word is written at RAM address 0.
- R2: In a cycle with `in_valid` high, `ram_wr_strobe` and `ram_wr_en` are high, `ram_wr_data` equals `in_data`, and `ram_wr_addr` equals the write pointer. The pointer then advances by one, modulo 2^ADDR_W. With `in_valid` low, both write controls are low and the pointer holds.
- R3: In a cycle with `in_valid` high and a nonzero effective delay D, `ram_rd_en` is high and `ram_rd_addr` equals (`ram_wr_addr` − D) modulo 2^ADDR_W. `ram_rd_en` is low otherwise, so the read address never equals the write address while a read is enabled.
- R4: With D ≥ 1 and the line primed, the word emitted for the k-th accepted input is the (k−D)-th accepted input.
- R5: `out_valid` is high in a cycle only if `in_valid` was high exactly two cycles earlier. Each accepted, primed input gives exactly one output, two cycles later.
- R6: With D = 0, the block reads nothing from the RAM, and each accepted word appears on `out_data` with `out_valid` two cycles later.
- R7: After reset, and after every change of the effective delay, the first D accepted words produce no output. From the (D+1)-th word onward, every accepted word produces an output.
- R8: A `depth` value of 2^ADDR_W or more acts as a delay of 2^ADDR_W − 1.
- R9: When the effective delay changes in the same cycle as an accepted word, that word counts as the first word under the new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the external RAM |
| rst | input | 1 | Synchronous reset, active high |
| depth | input | DEPTH_W | Requested delay in accepted samples |
| in_data | input | DATA_W | Incoming sample |
| in_valid | input | 1 | Marks `in_data` as an accepted sample |
| out_data | output | DATA_W | Delayed sample |
| out_valid | output | 1 | Marks `out_data` as valid |
| ram_wr_strobe | output | 1 | RAM write strobe |
| ram_wr_en | output | 1 | RAM write-port enable |
| ram_wr_addr | output | ADDR_W | RAM write address (write pointer) |
| ram_wr_data | output | DATA_W | RAM write data |
| ram_rd_en | output | 1 | RAM read-port enable |
| ram_rd_addr | output | ADDR_W | RAM read address |
| ram_rd_data | input | DATA_W | RAM read data, one cycle after the read |

## Verification
Two things can fall on the same clock: a change of the delay value and an accepted word. In that cycle the block must restart its priming count and also write the word, counting it as the first word under the new delay. The bench provokes this in a directed step, where the delay changes in a cycle that carries a valid word, and again through random delay changes that coincide with random valid patterns. A reference model is updated in the same order the requirements state: the delay change is applied first, then the write. From that model the bench predicts whether an output appears two cycles later and which earlier word it carries. The same bench also covers a pointer that wraps while the read address wraps behind it, so that this wraparound coincides with priming that restarts.

// File: rtl/vardly_pkg.sv
package vardly_pkg;
    // Source selected for the word that leaves the output register
    typedef enum logic {
        PATH_RAM = 1'b0,
        PATH_BYP = 1'b1
    } path_e;
endpackage

// File: rtl/vardly_fill.sv
// Effective-delay limiting and priming counter.
module vardly_fill #(
    parameter int ADDR_W  = 13,
    parameter int DEPTH_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DEPTH_W-1:0] depth_raw,
    input  logic               in_valid,
    output logic [ADDR_W-1:0]  depth_eff,
    output logic               emit,
    output logic               bypass
);
    localparam logic [DEPTH_W-1:0] LIMIT = DEPTH_W'((64'd1 << ADDR_W) - 64'd1);
    localparam logic [ADDR_W:0]    CAP   = {1'b1, {ADDR_W{1'b0}}};

    typedef struct packed {
        logic [ADDR_W-1:0] last;
        logic [ADDR_W:0]   cnt;
    } fill_t;

    fill_t fill_d, fill_q;
    logic [ADDR_W:0] cnt_now;

    always_comb begin
        fill_d = fill_q;
        if (depth_raw > LIMIT) begin
            depth_eff = LIMIT[ADDR_W-1:0];
        end else begin
            depth_eff = depth_raw[ADDR_W-1:0];
        end
        // a new delay restarts priming; a word in this cycle is the first one
        cnt_now     = (depth_eff != fill_q.last) ? '0 : fill_q.cnt;
        emit        = in_valid && (cnt_now >= {1'b0, depth_eff});
        bypass      = (depth_eff == '0);
        fill_d.last = depth_eff;
        if (in_valid && cnt_now != CAP) begin
            fill_d.cnt = cnt_now + 1'b1;
        end else begin
            fill_d.cnt = cnt_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end
endmodule

// File: rtl/vardly_addr.sv
// Write pointer and trailing read address.
module vardly_addr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] depth_eff,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] wp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d   = ptr_q;
        wr_addr = ptr_q.wp;
        rd_addr = ptr_q.wp - depth_eff;
        if (in_valid) begin
            ptr_d.wp = ptr_q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end
endmodule

// File: rtl/vardly_align.sv
// Two-stage output alignment: matches the RAM read cycle, then registers.
module vardly_align #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic              bypass,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] ram_rd_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import vardly_pkg::*;

    typedef struct packed {
        logic              s1_v;
        path_e             s1_path;
        logic [DATA_W-1:0] s1_data;
        logic              s2_v;
        logic [DATA_W-1:0] s2_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1_v    = emit;
        pipe_d.s1_path = bypass ? PATH_BYP : PATH_RAM;
        pipe_d.s1_data = in_data;
        pipe_d.s2_v    = pipe_q.s1_v;
        if (pipe_q.s1_path == PATH_BYP) begin
            pipe_d.s2_data = pipe_q.s1_data;
        end else begin
            pipe_d.s2_data = ram_rd_data;
        end
        out_valid = pipe_q.s2_v;
        out_data  = pipe_q.s2_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end
endmodule

// File: rtl/vardly_buf.sv
module vardly_buf #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 13,
    parameter int DEPTH_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_valid,
    output logic               ram_wr_strobe,
    output logic               ram_wr_en,
    output logic [ADDR_W-1:0]  ram_wr_addr,
    output logic [DATA_W-1:0]  ram_wr_data,
    output logic               ram_rd_en,
    output logic [ADDR_W-1:0]  ram_rd_addr,
    input  logic [DATA_W-1:0]  ram_rd_data
);
    logic [ADDR_W-1:0] depth_eff;
    logic              emit;
    logic              bypass;

    vardly_fill #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .depth_raw (depth),
        .in_valid  (in_valid),
        .depth_eff (depth_eff),
        .emit      (emit),
        .bypass    (bypass)
    );

    vardly_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .depth_eff (depth_eff),
        .wr_addr   (ram_wr_addr),
        .rd_addr   (ram_rd_addr)
    );

    vardly_align #(.DATA_W(DATA_W)) u_align (
        .clk         (clk),
        .rst         (rst),
        .emit        (emit),
        .bypass      (bypass),
        .in_data     (in_data),
        .ram_rd_data (ram_rd_data),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    always_comb begin
        ram_wr_strobe = in_valid;
        ram_wr_en     = in_valid;
        ram_wr_data   = in_data;
        ram_rd_en     = in_valid && !bypass;
    end
endmodule

// File: rtl/vardly_chk.sv
module vardly_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 13,
    parameter int DEPTH_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [DEPTH_W-1:0] depth,
    input logic [DATA_W-1:0]  in_data,
    input logic               in_valid,
    input logic [DATA_W-1:0]  out_data,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  ram_wr_addr,
    input logic               ram_rd_en,
    input logic [ADDR_W-1:0]  ram_rd_addr
);
    localparam logic [DEPTH_W-1:0] SPAN = DEPTH_W'(64'd1 << ADDR_W);

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid) && !$past(rst)) |-> ram_wr_addr == ADDR_W'($past(ram_wr_addr) + 1'b1));

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> ram_wr_addr == $past(ram_wr_addr));

    // R3
    no_collide_chk: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> ram_rd_addr != ram_wr_addr);

    // R5
    out_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R6
    bypass_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(depth, 2) == '0 && !$past(rst, 2)) |-> out_data == $past(in_data, 2));

    // R7
    prime_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$past(rst) && depth != $past(depth) && depth != '0
         && depth < SPAN && $past(depth) < SPAN) |-> ##2 !out_valid);
endmodule

bind vardly_buf vardly_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_chk (.*);

// File: tb/sim_vardly_buf.sv
module sim_vardly_buf;
    localparam int AW  = 6;
    localparam int DW  = 32;
    localparam int M   = 1 << AW;
    localparam int PER = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   depth;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          ram_wr_strobe, ram_wr_en, ram_rd_en;
    logic [AW-1:0] ram_wr_addr, ram_rd_addr;
    logic [DW-1:0] ram_wr_data, ram_rd_data;

    always #(PER / 2) clk = ~clk;

    vardly_buf #(.DATA_W(DW), .ADDR_W(AW), .DEPTH_W(32)) u0 (
        .clk(clk), .rst(rst), .depth(depth), .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid),
        .ram_wr_strobe(ram_wr_strobe), .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr),
        .ram_wr_data(ram_wr_data), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data)
    );

    // external RAM model: one-cycle registered read
    logic [DW-1:0] mem [M];
    always_ff @(posedge clk) begin
        if (ram_wr_en && ram_wr_strobe) mem[ram_wr_addr] <= ram_wr_data;
        if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
    end

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string ph     = "R1";

    logic [DW-1:0] hist [M];
    int            m_last, m_cnt, m_wp;
    logic          e_v [2];
    logic [DW-1:0] e_d [2];
    string         e_t [2];

    function automatic int clampd(input logic [31:0] d);
        return (d >= 32'(M)) ? M - 1 : int'(d);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic model_clear();
        m_last = 0; m_cnt = 0; m_wp = 0;
        for (int i = 0; i < 2; i++) begin
            e_v[i] = 1'b0; e_d[i] = '0; e_t[i] = "R1";
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic cyc(input bit v, input logic [DW-1:0] d, input logic [31:0] dep);
        int  deff;
        bit  em;
        logic [DW-1:0] xd;
        string tg;
        chk(out_valid === e_v[1], {ph, " out_valid ", e_t[1]}, 64'(out_valid), 64'(e_v[1]));
        if (e_v[1])
            chk(out_data === e_d[1], {ph, " out_data ", e_t[1]}, 64'(out_data), 64'(e_d[1]));
        in_valid = v; in_data = d; depth = dep;
        #1;
        deff = clampd(dep);
        if (deff != m_last) begin
            m_cnt = 0; m_last = deff;   // R9: change applied before this cycle's write
        end
        em = 1'b0; xd = '0; tg = "R5";
        if (v) begin
            chk(ram_wr_en && ram_wr_strobe, {ph, " R2 write controls"}, 64'({ram_wr_en, ram_wr_strobe}), 64'h3);
            chk(ram_wr_addr == AW'(m_wp), {ph, " R2 write address"}, 64'(ram_wr_addr), 64'(m_wp));
            chk(ram_wr_data == d, {ph, " R2 write data"}, 64'(ram_wr_data), 64'(d));
            if (deff != 0) begin
                chk(ram_rd_en, {ph, " R3 read enable"}, 64'(ram_rd_en), 64'h1);
                chk(ram_rd_addr == AW'((m_wp - deff + M) % M), {ph, " R3 read address"},
                    64'(ram_rd_addr), 64'((m_wp - deff + M) % M));
            end else begin
                chk(!ram_rd_en, {ph, " R6 no read in bypass"}, 64'(ram_rd_en), 64'h0);
            end
            em = (m_cnt >= deff);
            if (!em) tg = "R7";
            else if (deff == 0) tg = "R6";
            else tg = "R4";
            xd = (deff == 0) ? d : hist[(m_wp - deff + M) % M];
            hist[m_wp] = d;
            m_wp = (m_wp + 1) % M;
            if (m_cnt < M) m_cnt++;
        end else begin
            chk(!ram_wr_en && !ram_wr_strobe && !ram_rd_en, {ph, " R2 idle ports"},
                64'({ram_wr_en, ram_wr_strobe, ram_rd_en}), 64'h0);
        end
        e_v[1] = e_v[0]; e_d[1] = e_d[0]; e_t[1] = e_t[0];
        e_v[0] = em;     e_d[0] = xd;     e_t[0] = tg;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        ph = "R1";
        chk(out_valid === 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
    endtask

    function automatic logic [31:0] pick_depth();
        case ($urandom % 5)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'($urandom % M);
            3: return 32'(M - 1);
            default: return 32'(M + ($urandom % 200));
        endcase
    endfunction

    initial begin
        #(PER * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R5 watchdog expired: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] dep;
        void'($urandom(32'd4099));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; depth = '0;
        @(negedge clk);
        do_reset();
        // R1: first word after reset lands at address 0 (checked inside cyc)
        cyc(1'b1, 32'hA000_0000, 32'd0);
        cyc(1'b0, 32'h0, 32'd0);
        cyc(1'b0, 32'h0, 32'd0);

        // R4 / R7: continuous stream, delay 3
        ph = "R4";
        for (int i = 0; i < 20; i++) cyc(1'b1, 32'h1000 + 32'(i), 32'd3);

        // R5: gapped stream, delay 5
        ph = "R5";
        for (int i = 0; i < 60; i++) cyc(($urandom % 2) == 1, $urandom, 32'd5);

        // R6: bypass with gaps
        ph = "R6";
        for (int i = 0; i < 30; i++) cyc(($urandom % 3) != 0, $urandom, 32'd0);

        // R8: oversized delays act as M-1; pointer wraps
        ph = "R8";
        for (int i = 0; i < 150; i++) cyc(1'b1, $urandom, 32'd1000);
        for (int i = 0; i < 20; i++)  cyc(1'b1, $urandom, 32'(M));   // clamps to same value, no re-prime
        for (int i = 0; i < 10; i++)  cyc(1'b1, $urandom, 32'hFFFF_FFFF);

        // R9: delay change in the same cycle as a valid word
        ph = "R9";
        for (int i = 0; i < 8; i++)  cyc(1'b1, 32'h2000 + 32'(i), 32'd2);
        for (int i = 0; i < 12; i++) cyc(1'b1, 32'h3000 + 32'(i), 32'd4);
        cyc(1'b1, 32'h4000, 32'd0);
        cyc(1'b1, 32'h4001, 32'd1);
        cyc(1'b1, 32'h4002, 32'd1);
        cyc(1'b1, 32'h4003, 32'd1);

        // R1: reset in mid-stream
        for (int i = 0; i < 5; i++) cyc(1'b1, $urandom, 32'd3);
        do_reset();
        for (int i = 0; i < 10; i++) cyc(1'b1, 32'h5000 + 32'(i), 32'd3);

        // mixed random run
        ph = "R7";
        dep = 32'd2;
        for (int i = 0; i < 2000; i++) begin
            if (i % 97 == 0) dep = pick_depth();
            cyc(($urandom % 4) != 0, $urandom, dep);
        end
        cyc(1'b0, 32'h0, dep);
        cyc(1'b0, 32'h0, dep);
        cyc(1'b0, 32'h0, dep);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule